// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock for an I2C master from a fast functional clock. A programmable prescaler divides the functional clock into an internal tick. The low half of each SCL period lasts a programmed number of ticks plus a fixed seven. The high half lasts a programmed number of ticks plus a fixed five, and it does not begin counting until the line is actually seen high. Slow rise times and slaves that hold the clock low therefore lengthen the high half by whole ticks.

The line is driven open-drain. `scl_oe` high pulls SCL low, and `scl_oe` low releases it. The sensed line `scl_in` passes through a synchronizer before it is used. The rest of the bus engine gets three one-cycle strobes. `tick` marks the internal tick. `fall_stb` marks each falling edge, where data is launched. `rise_stb` marks the moment the line is confirmed high, where data is sampled.

The three settings are captured at the start of every low half, so they can be rewritten at any time without breaking a phase. The generator runs only while it is enabled and in master mode. Otherwise it sits idle with the line released. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `scl_rate_gen`

## Requirements
- R1: While running, `tick` is a one-cycle pulse every (prescaler + 1) functional clocks, so 10 pulses fall in any 40-cycle window with prescaler 3. No tick occurs while the generator is idle.
- R2: Each low half (`scl_oe` = 1) lasts (low_cfg + 7) × (prescaler + 1) functional clocks.
- R3: When the released line is seen high by the first tick after release, the high half (`scl_oe` = 0) lasts (high_cfg + 5) × (prescaler + 1) functional clocks.
- R4: Every tick that occurs before the synchronized line reads high is added, whole, to the high half. With prescaler 0 this gives high_cfg + 7 clocks, because the two-stage synchronizer costs 2 ticks. With prescaler 3, a line held low for 10 clocks after release gives 36 clocks when high_cfg is 1.
- R5: In slave mode (`master` = 0) `scl_oe` never asserts and no strobe fires.
- R6: The output is open-drain. After reset and while idle, `scl_oe` is 0 (line released).
- R7: The prescaler, low and high settings are captured only when a low half starts. A change made mid-period leaves the current low and high halves unchanged and applies from the next low half.
- R8: `fall_stb` is high for exactly one cycle, the first cycle of each low half, and is never high at any other time.
- R9: `rise_stb` is high for exactly one cycle per high half, while `scl_oe` is 0.
- R10: Deasserting `en` releases the line and clears all counters by the next clock edge. Re-enabling starts a complete low half.
- R11: With prescaler 23 and low and high settings of 4, the low half is 264 clocks and the high half 216 clocks. From 48 MHz this is 5.5 us and 4.5 us, which is 100 kHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable |
| master | input | 1 | 1 = master mode (generate SCL), 0 = slave mode (idle) |
| psc_cfg | input | PSC_W | Prescaler setting; tick period is psc_cfg + 1 clocks |
| low_cfg | input | CNT_W | Low-phase setting; low half is low_cfg + 7 ticks |
| high_cfg | input | CNT_W | High-phase setting; high half is high_cfg + 5 counted ticks |
| scl_in | input | 1 | Sensed SCL line level, asynchronous |
| scl_oe | output | 1 | Open-drain drive: 1 pulls SCL low, 0 releases |
| tick | output | 1 | One-cycle internal tick strobe |
| fall_stb | output | 1 | One-cycle strobe at each SCL falling edge |
| rise_stb | output | 1 | One-cycle strobe when SCL is confirmed high |

## Verification
The embedded properties make no assumption about when the settings change or how `scl_in` behaves. They rely only on `en` and `master` being synchronous to `clk`. The bench models the line as the wired-AND of the block's own drive and a bench-controlled hold that stands in for a stretching slave. It changes settings and enables only at falling clock edges. Stretch lengths and prescalers are chosen so that each expected phase length follows from the tick arithmetic, including the two-cycle synchronizer delay.

// File: rtl/scl_pkg.sv
package scl_pkg;
  // Fixed tick offsets added to the programmed phase lengths
  localparam int LOW_OFS  = 7;
  localparam int HIGH_OFS = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] lim,
  output logic             tick
);
  logic [PSC_W-1:0] pc;

  assign tick = run && (pc == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pc <= '0;
    else if (!run)        pc <= '0;
    else if (pc == lim)   pc <= '0;
    else                  pc <= pc + 1'b1;
  end

  // The captured limit never drops below the running count (R1, R7)
  assert_pc_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pc <= lim)
    else $error("prescale count exceeds limit");
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             line_hi,
  input  logic [PSC_W-1:0] psc_cfg,
  input  logic [CNT_W-1:0] low_cfg,
  input  logic [CNT_W-1:0] high_cfg,
  output logic             run,
  output logic [PSC_W-1:0] psc_q,
  output logic             scl_oe,
  output logic             fall_stb,
  output logic             rise_stb
);
  localparam int CW = CNT_W + 1;

  scl_phase_e       state;
  logic [CW-1:0]    cnt;
  logic [CNT_W-1:0] low_q, high_q;
  logic [CW-1:0]    low_tgt, high_tgt;

  assign low_tgt  = {1'b0, low_q}  + CW'(LOW_OFS - 1);
  assign high_tgt = {1'b0, high_q} + CW'(HIGH_OFS - 1);
  assign run      = (state != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      scl_oe   <= 1'b0;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      psc_q    <= '0;
      low_q    <= '0;
      high_q   <= '0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (!active) begin
        state  <= PH_IDLE;
        cnt    <= '0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          PH_IDLE: begin
            state    <= PH_LOW;
            cnt      <= '0;
            scl_oe   <= 1'b1;
            fall_stb <= 1'b1;
            psc_q    <= psc_cfg;
            low_q    <= low_cfg;
            high_q   <= high_cfg;
          end
          PH_LOW: begin
            if (tick) begin
              if (cnt == low_tgt) begin
                state  <= PH_WAIT;
                cnt    <= '0;
                scl_oe <= 1'b0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          PH_WAIT: begin
            if (tick && line_hi) begin
              state    <= PH_HIGH;
              cnt      <= CW'(1);
              rise_stb <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (tick) begin
              if (cnt == high_tgt) begin
                state    <= PH_LOW;
                cnt      <= '0;
                scl_oe   <= 1'b1;
                fall_stb <= 1'b1;
                psc_q    <= psc_cfg;
                low_q    <= low_cfg;
                high_q   <= high_cfg;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= PH_IDLE;
        endcase
      end
    end
  end

  assert_low_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOW) |-> cnt <= low_tgt)
    else $error("low count overran target");

  assert_high_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HIGH) |-> (cnt <= high_tgt && cnt != '0))
    else $error("high count out of range");

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!scl_oe && !fall_stb && !rise_stb))
    else $error("drive or strobe while inactive");

  assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (scl_oe && !$past(scl_oe)))
    else $error("fall strobe not at drive start");

  assert_rise_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> !scl_oe)
    else $error("rise strobe while driving low");

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && $past(scl_oe)) |-> ($stable(low_q) && $stable(high_q) && $stable(psc_q)))
    else $error("settings changed inside low half");
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int PSC_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic [PSC_W-1:0] psc_cfg,
  input  logic [CNT_W-1:0] low_cfg,
  input  logic [CNT_W-1:0] high_cfg,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             tick,
  output logic             fall_stb,
  output logic             rise_stb
);
  logic             active;
  logic             line_hi;
  logic             run;
  logic [PSC_W-1:0] psc_q;

  assign active = en && master;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (line_hi)
  );

  scl_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .lim   (psc_q),
    .tick  (tick)
  );

  scl_phase_fsm #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .tick     (tick),
    .line_hi  (line_hi),
    .psc_cfg  (psc_cfg),
    .low_cfg  (low_cfg),
    .high_cfg (high_cfg),
    .run      (run),
    .psc_q    (psc_q),
    .scl_oe   (scl_oe),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb)
  );

  // Slave mode never pulls the line (R5)
  assert_slave_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && $past(!master)) |-> (!scl_oe && !tick))
    else $error("activity in slave mode");
endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, master, hold;
  logic [7:0] psc_cfg, low_cfg, high_cfg;
  logic       scl_in, scl_oe, tick, fall_stb, rise_stb;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #4 clk = ~clk;

  // Wired-AND line: pulled up unless the block drives or the bench stretches
  assign scl_in = ~scl_oe & ~hold;

  scl_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master),
    .psc_cfg(psc_cfg), .low_cfg(low_cfg), .high_cfg(high_cfg),
    .scl_in(scl_in), .scl_oe(scl_oe), .tick(tick),
    .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    int g = 0;
    @(negedge clk);
    while (!fall_stb && g < 20000) begin
      g++;
      @(negedge clk);
    end
  endtask

  // Starts at a negedge where fall_stb is high; ends at the next one
  task automatic measure(output int lo, output int hi, output int rises, output int falls);
    lo = 0; hi = 0; rises = 0; falls = 0;
    while (scl_oe && lo < 20000) begin
      if (fall_stb) falls++;
      if (rise_stb) rises++;
      lo++;
      @(negedge clk);
    end
    while (!scl_oe && hi < 20000) begin
      if (rise_stb) rises++;
      if (fall_stb) falls++;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input int p, input int l, input int h);
    psc_cfg  = 8'(p);
    low_cfg  = 8'(l);
    high_cfg = 8'(h);
  endtask

  task automatic t_reset();
    chk("R6 oe in reset", int'(scl_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 oe idle", int'(scl_oe), 0);
    chk("R1 tick idle", int'(tick), 0);
    chk("R8 fall idle", int'(fall_stb), 0);
  endtask

  task automatic t_basic();
    int lo, hi, rs, fs, tk;
    set_cfg(3, 2, 1);
    en = 1'b1; master = 1'b1;
    wait_fall();
    measure(lo, hi, rs, fs);
    chk("R2 low basic", lo, 36);
    chk("R3 high basic", hi, 24);
    chk("R9 rise count", rs, 1);
    chk("R8 fall count", fs, 1);
    chk("R8 fall at next low", int'(fall_stb), 1);
    measure(lo, hi, rs, fs);
    chk("R2 low second", lo, 36);
    chk("R3 high second", hi, 24);
    tk = 0;
    for (int i = 0; i < 40; i++) begin
      if (tick) tk++;
      @(negedge clk);
    end
    chk("R1 ticks per 40", tk, 10);
  endtask

  task automatic t_100k();
    int lo, hi, rs, fs;
    en = 1'b0;
    @(negedge clk);
    set_cfg(23, 4, 4);
    en = 1'b1;
    wait_fall();
    measure(lo, hi, rs, fs);
    chk("R11 low 5.5us", lo, 264);
    chk("R11 high 4.5us", hi, 216);
    chk("R11 period", lo + hi, 480);
  endtask

  task automatic t_fast();
    int lo, hi, rs, fs;
    en = 1'b0;
    @(negedge clk);
    set_cfg(0, 0, 0);
    en = 1'b1;
    wait_fall();
    measure(lo, hi, rs, fs);
    chk("R2 low psc0", lo, 7);
    chk("R4 high psc0 sync ticks", hi, 7);
    chk("R9 rise psc0", rs, 1);
  endtask

  task automatic t_stretch();
    int lo, hi, rs;
    en = 1'b0;
    @(negedge clk);
    set_cfg(3, 2, 1);
    en = 1'b1;
    wait_fall();
    hold = 1'b1;
    lo = 0;
    while (scl_oe && lo < 20000) begin lo++; @(negedge clk); end
    hi = 0; rs = 0;
    while (!scl_oe && hi < 20000) begin
      if (hi == 10) hold = 1'b0;
      if (rise_stb) rs++;
      hi++;
      @(negedge clk);
    end
    chk("R4 stretched high", hi, 36);
    chk("R9 rise stretched", rs, 1);
  endtask

  task automatic t_cfg_change();
    int lo, hi, rs, fs;
    wait_fall();
    set_cfg(3, 5, 3);
    measure(lo, hi, rs, fs);
    chk("R7 old low kept", lo, 36);
    chk("R7 old high kept", hi, 24);
    measure(lo, hi, rs, fs);
    chk("R7 new low", lo, 48);
    chk("R7 new high", hi, 32);
  endtask

  task automatic t_disable();
    int lo, hi, rs, fs;
    set_cfg(3, 2, 1);
    wait_fall();
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R10 released next clk", int'(scl_oe), 0);
    repeat (3) @(negedge clk);
    chk("R1 no tick disabled", int'(tick), 0);
    en = 1'b1;
    wait_fall();
    measure(lo, hi, rs, fs);
    chk("R10 full low after restart", lo, 36);
  endtask

  task automatic t_slave();
    int act = 0;
    en = 1'b0;
    @(negedge clk);
    master = 1'b0;
    en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (scl_oe || fall_stb || rise_stb || tick) act++;
    end
    chk("R5 slave quiet", act, 0);
    en = 1'b0;
    master = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; master = 1'b1; hold = 1'b0;
    set_cfg(0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_cfg_change();
    t_100k();
    t_fast();
    t_stretch();
    t_disable();
    t_slave();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule